// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers interrupt requests for a small processor core and picks one to serve. There are 24 vector slots, each two program words apart. Slot 0 belongs to reset and never raises an interrupt. Slots 1 to 8 come from eight external pins. Slots 9 to 23 come from internal peripherals: first the three timers' compare, overflow and capture events, then serial transfer complete, the three UART events, converter done, EEPROM ready and the analog comparator. Every request sets a latched pending flag. A flag stays set whether or not its source is enabled.

A pending flag whose source is enabled can raise `irq_o`, but only while the global enable bit is set. The lowest-numbered slot among those candidates goes out on `vec_o` as a word address. When the core accepts, it pulses `ack_i`. This clears the served flag and the global enable bit, and returning from the handler pulses `gie_set_i`. Software programs the enable masks and the external sense controls through a small write port.

Top module: `vic_top`

## Requirements
- R1: While `irq_o` is high, `vec_o` equals twice the selected slot number. External pin n maps to slot n+1. Bit j of `periph_req_i` maps to slot 9+j. While `irq_o` is low, `vec_o` is 0.
- R2: When several enabled flags are pending, the slot with the lowest number is presented.
- R3: `irq_o` stays low while the global enable bit (`gie_o`) is 0, even when an enabled flag is pending.
- R4: An acknowledge while `irq_o` is high clears `gie_o`, and `irq_o` is low in the following cycle.
- R5: A `gie_set_i` pulse sets `gie_o` at the next edge and a `gie_clr_i` pulse clears it. When both arrive together, clear wins.
- R6: An acknowledge clears only the pending flag of the presented slot. Other pending flags stay latched and are served later in priority order.
- R7: A request sets its pending flag even while its source is disabled. Enabling the source later raises `irq_o` for it.
- R8: Write select 0 writes the external mask: bit n enables pin n. Write select 2 writes the timer mask, where bit 7 enables slot 9 and each lower bit enables the next slot, so bit 0 enables slot 16. Write select 3 writes the peripheral mask, where bit p enables slot 17+p.
- R9: Write select 1 writes the sense codes, with pin n in data bits 2n+1:2n. Code 00 or 01 means low level, 10 means falling edge and 11 means rising edge. Pins pass through two synchronizer stages, so a pin change sets its flag at the third rising clock edge.
- R10: In low-level mode, a pin held low sets its flag again right after each acknowledge.
- R11: After reset all masks and sense codes are 0, no flag is pending, `gie_o` is 0, `irq_o` is low and `vec_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_pin_i | input | 8 | External interrupt pins (asynchronous) |
| periph_req_i | input | 15 | Peripheral request pulses for slots 9 to 23 |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 external mask, 1 sense, 2 timer mask, 3 peripheral mask |
| wr_data_i | input | 16 | Write data |
| gie_set_i | input | 1 | Set global enable (enable or return from handler) |
| gie_clr_i | input | 1 | Clear global enable |
| ack_i | input | 1 | Core accepts the presented interrupt |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 6 | Word address of the handler vector |
| gie_o | output | 1 | Current global enable bit |

## Verification
The bound checker watches several properties on every cycle. These are: the even, nonzero vector while a request is up, and a zero vector otherwise; the absence of any lower-numbered candidate than the one presented; the drop of `irq_o` and `gie_o` after an accepted acknowledge; the survival of unserved pending flags; and the effect of the set and clear strobes. The mapping of each pin and peripheral line to its slot, the reversed timer mask layout, the three-edge synchronizer latency, the sense modes and the level re-trigger after acknowledge all depend on stimulus sequences. Only the bench's directed scenarios show them.

// File: rtl/vic_pkg.sv
package vic_pkg;

    typedef enum logic [1:0] {
        WR_EXT_MASK = 2'd0,
        WR_SENSE    = 2'd1,
        WR_TMR_MASK = 2'd2,
        WR_PER_MASK = 2'd3
    } wr_sel_e;

    typedef enum logic [1:0] {
        SENSE_LOW_A = 2'b00,
        SENSE_LOW_B = 2'b01,
        SENSE_FALL  = 2'b10,
        SENSE_RISE  = 2'b11
    } sense_e;

endpackage

// File: rtl/vic_sense.sv
module vic_sense #(
    parameter int N = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [N-1:0]   pin_i,
    input  logic [2*N-1:0] sense_i,
    output logic [N-1:0]   hit_o
);
    import vic_pkg::*;

    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{s1: '1, s2: '1, s3: '1};
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar n = 0; n < N; n++) begin : g_pin
        sense_e mode;
        assign mode = sense_e'(sense_i[2*n+1:2*n]);
        always_comb begin
            case (mode)
                SENSE_FALL: hit_o[n] = !st_q.s2[n] && st_q.s3[n];
                SENSE_RISE: hit_o[n] = st_q.s2[n] && !st_q.s3[n];
                default:    hit_o[n] = !st_q.s2[n];
            endcase
        end
    end

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
    parameter int N = 24,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  cand_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand_i[i]) idx_o = IW'(i);
        end
    end

    assign any_o = |cand_i;

endmodule

// File: rtl/vic_top.sv
module vic_top #(
    parameter int NUM_EXT = 8,
    parameter int NUM_TMR = 8,
    parameter int NUM_PER = 7,
    localparam int NUM_INT = NUM_TMR + NUM_PER,
    localparam int NSLOT   = 1 + NUM_EXT + NUM_INT,
    localparam int SLOT_W  = $clog2(NSLOT),
    localparam int VEC_W   = SLOT_W + 1,
    localparam int DW      = 2 * NUM_EXT
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EXT-1:0] ext_pin_i,
    input  logic [NUM_INT-1:0] periph_req_i,
    input  logic               wr_en_i,
    input  logic [1:0]         wr_sel_i,
    input  logic [DW-1:0]      wr_data_i,
    input  logic               gie_set_i,
    input  logic               gie_clr_i,
    input  logic               ack_i,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o,
    output logic               gie_o
);
    import vic_pkg::*;

    localparam int TMR_BASE = 1 + NUM_EXT;
    localparam int PER_BASE = TMR_BASE + NUM_TMR;

    typedef struct packed {
        logic [NSLOT-1:0]   pend;
        logic               gie;
        logic [NUM_EXT-1:0] ext_mask;
        logic [DW-1:0]      sense;
        logic [NUM_TMR-1:0] tmr_mask;
        logic [NUM_PER-1:0] per_mask;
    } state_t;

    state_t st_d, st_q;

    logic [NUM_EXT-1:0] ext_hit;
    logic [NSLOT-1:0]   set_vec;
    logic [NSLOT-1:0]   en_vec;
    logic [NSLOT-1:0]   cand;
    logic [NSLOT-1:0]   pend_vis;
    logic               any_cand;
    logic [SLOT_W-1:0]  sel_idx;
    logic               take;

    vic_sense #(.N(NUM_EXT)) i_sense (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pin_i   (ext_pin_i),
        .sense_i (st_q.sense),
        .hit_o   (ext_hit)
    );

    assign set_vec = {periph_req_i, ext_hit, 1'b0};

    assign en_vec[0] = 1'b0;
    for (genvar n = 0; n < NUM_EXT; n++) begin : g_en_ext
        assign en_vec[1 + n] = st_q.ext_mask[n];
    end
    for (genvar k = 0; k < NUM_TMR; k++) begin : g_en_tmr
        assign en_vec[TMR_BASE + k] = st_q.tmr_mask[NUM_TMR - 1 - k];
    end
    for (genvar p = 0; p < NUM_PER; p++) begin : g_en_per
        assign en_vec[PER_BASE + p] = st_q.per_mask[p];
    end

    assign cand = st_q.pend & en_vec;

    vic_prio #(.N(NSLOT)) i_prio (
        .cand_i (cand),
        .any_o  (any_cand),
        .idx_o  (sel_idx)
    );

    assign irq_o    = st_q.gie && any_cand;
    assign take     = ack_i && irq_o;
    assign vec_o    = irq_o ? {sel_idx, 1'b0} : '0;
    assign gie_o    = st_q.gie;
    assign pend_vis = st_q.pend;

    always_comb begin
        st_d = st_q;
        st_d.pend = st_q.pend & ~(take ? (NSLOT'(1) << sel_idx) : '0);
        st_d.pend = st_d.pend | set_vec;
        if (take || gie_clr_i) begin
            st_d.gie = 1'b0;
        end else if (gie_set_i) begin
            st_d.gie = 1'b1;
        end
        if (wr_en_i) begin
            case (wr_sel_e'(wr_sel_i))
                WR_EXT_MASK: st_d.ext_mask = wr_data_i[NUM_EXT-1:0];
                WR_SENSE:    st_d.sense    = wr_data_i;
                WR_TMR_MASK: st_d.tmr_mask = wr_data_i[NUM_TMR-1:0];
                default:     st_d.per_mask = wr_data_i[NUM_PER-1:0];
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

module vic_checker #(
    parameter int NSLOT = 24,
    parameter int VEC_W = 6
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             irq_o,
    input logic             ack_i,
    input logic [VEC_W-1:0] vec_o,
    input logic             gie_o,
    input logic             gie_set_i,
    input logic             gie_clr_i,
    input logic [NSLOT-1:0] pend,
    input logic [NSLOT-1:0] en
);
    logic [NSLOT-1:0] sel_bit;
    logic [NSLOT-1:0] below;
    assign sel_bit = NSLOT'(1) << vec_o[VEC_W-1:1];
    assign below   = sel_bit - NSLOT'(1);

    // R1
    a_r1_vec_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (vec_o[0] == 1'b0 && vec_o != '0));
    // R1 / R11
    a_r11_idle_vec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !irq_o |-> vec_o == '0);
    // R2
    a_r2_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ((pend & en & below) == '0));
    // R4
    a_r4_ack_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=> (!irq_o && !gie_o));
    // R5
    a_r5_set_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gie_set_i && !gie_clr_i && !(ack_i && irq_o)) |=> gie_o);
    a_r5_clr_gie: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gie_clr_i |=> !gie_o);
    // R6
    a_r6_others_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_i && irq_o) |=>
            ((pend & $past(pend & ~sel_bit)) == $past(pend & ~sel_bit)));
endmodule

bind vic_top vic_checker #(.NSLOT(NSLOT), .VEC_W(VEC_W)) i_vic_checker (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .irq_o     (irq_o),
    .ack_i     (ack_i),
    .vec_o     (vec_o),
    .gie_o     (gie_o),
    .gie_set_i (gie_set_i),
    .gie_clr_i (gie_clr_i),
    .pend      (pend_vis),
    .en        (en_vec)
);

// File: tb/test_vic_top.sv
module test_vic_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  ext_pin;
    logic [14:0] periph_req;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        gie_set, gie_clr, ack;
    logic        irq;
    logic [5:0]  vec;
    logic        gie;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    vic_top i_vic_top (
        .clk_i (clk), .rst_ni (rst_n), .ext_pin_i (ext_pin),
        .periph_req_i (periph_req), .wr_en_i (wr_en), .wr_sel_i (wr_sel),
        .wr_data_i (wr_data), .gie_set_i (gie_set), .gie_clr_i (gie_clr),
        .ack_i (ack), .irq_o (irq), .vec_o (vec), .gie_o (gie)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; ext_pin = '1; periph_req = '0; wr_en = 1'b0;
        wr_sel = '0; wr_data = '0; gie_set = 1'b0; gie_clr = 1'b0; ack = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [15:0] data);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_gie();
        gie_set = 1'b1; @(negedge clk); gie_set = 1'b0;
    endtask

    task automatic req(input int j);
        periph_req[j] = 1'b1; @(negedge clk); periph_req[j] = 1'b0;
    endtask

    task automatic do_ack();
        ack = 1'b1; @(negedge clk); ack = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R11 irq", irq, 0);
        check("R11 vec", vec, 0);
        check("R11 gie", gie, 0);
        req(8);
        set_gie();
        check("R11 masks cleared, irq", irq, 0);
    endtask

    task automatic t_priority();
        do_reset();
        wr(2'd0, 16'h00FF); wr(2'd2, 16'h00FF); wr(2'd3, 16'h007F);
        periph_req[14] = 1'b1; periph_req[3] = 1'b1;
        @(negedge clk);
        periph_req = '0;
        check("R3 no irq with gie 0", irq, 0);
        set_gie();
        check("R5 gie set", gie, 1);
        check("R2 lowest wins", vec, 24);
        do_ack();
        check("R4 irq after ack", irq, 0);
        check("R4 gie after ack", gie, 0);
        set_gie();
        check("R6 other flag kept", vec, 46);
        check("R1 slot 23 vector", irq, 1);
        do_ack();
        set_gie();
        check("R6 served flag cleared", irq, 0);
        check("R1 idle vec", vec, 0);
    endtask

    task automatic t_gie();
        do_reset();
        wr(2'd3, 16'h0001);
        req(8);
        gie_set = 1'b1; gie_clr = 1'b1;
        @(negedge clk);
        gie_set = 1'b0; gie_clr = 1'b0;
        check("R5 clear wins", gie, 0);
        check("R3 irq blocked", irq, 0);
        set_gie();
        check("R1 slot 17 vector", vec, 34);
        gie_clr = 1'b1; @(negedge clk); gie_clr = 1'b0;
        check("R5 clear strobe", gie, 0);
        check("R3 irq low after clear", irq, 0);
    endtask

    task automatic t_mask_latch();
        do_reset();
        set_gie();
        req(10);
        check("R7 masked no irq", irq, 0);
        wr(2'd3, 16'h0004);
        check("R7 latched flag", vec, 38);
    endtask

    task automatic t_timer_layout();
        do_reset();
        set_gie();
        wr(2'd2, 16'h0001);
        req(0);
        check("R8 slot 9 off under bit0", irq, 0);
        req(7);
        check("R8 bit0 is slot 16", vec, 32);
        wr(2'd2, 16'h0080);
        check("R8 bit7 is slot 9", vec, 18);
    endtask

    task automatic t_ext_sense();
        do_reset();
        wr(2'd0, 16'h0025);
        wr(2'd1, 16'h0032);
        set_gie();
        ext_pin[2] = 1'b0;
        repeat (5) @(negedge clk);
        check("R9 rise mode ignores fall", irq, 0);
        ext_pin[2] = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 sync latency", irq, 0);
        @(negedge clk);
        check("R9 rising edge flag", irq, 1);
        check("R1 pin 2 vector", vec, 6);
        do_ack();
        set_gie();
        check("R9 edge sets once", irq, 0);
        ext_pin[0] = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 falling edge pin 0", vec, 2);
        do_ack();
        set_gie();
        ext_pin[5] = 1'b0;
        repeat (4) @(negedge clk);
        check("R9 low level pin 5", vec, 12);
        do_ack();
        set_gie();
        check("R10 level re-pends", vec, 12);
        ext_pin[5] = 1'b1;
        repeat (4) @(negedge clk);
        do_ack();
        set_gie();
        check("R10 released pin quiet", irq, 0);
    endtask

    initial begin
        t_reset();
        t_priority();
        t_gie();
        t_mask_latch();
        t_timer_layout();
        t_ext_sense();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule